// File: doc/BRIEF.md
# Digitally Trimmed Real-Time-Clock Prescaler

This block turns a stream of oscillator tick enables (nominally 32.768 kHz, one clock-wide pulse per oscillator period) into a one-cycle "second" enable for the timekeeping counters. The tick rate is trimmed digitally. A sign bit and a 5-bit magnitude tell a scheduler how many ticks to drop, or how many extra counts to add, in each fixed correction window. The corrections are spread evenly across the window rather than applied in a burst.

Software reaches the block through a small byte-wide register port. A mode register holds the trim-mode switch. A trim register holds the sign and the magnitude, and it accepts writes only while trim mode is on. In trim mode the shared output pin carries a 512 Hz square wave that is taken ahead of the correction point, so it can be measured against a reference without the correction showing. The alarm is gated off in this mode. Outside trim mode the pin carries the alarm event from the surrounding clock logic.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: Writing address 00h sets the trim-mode switch from data bit 0; reading 00h returns that bit in bit 0 and zeros elsewhere; it is 0 after reset.
- R2: With trim mode at 1, `acs_out` is the 512 Hz square wave (period 64 ticks, 32 high) and `alarm_en` is 0; with trim mode at 0, `acs_out` follows `alarm_hit` and `alarm_en` is 1.
- R3: Address 01h holds the trim code, magnitude in bits 4:0 and sign in bit 5. A write to 01h takes effect only while trim mode is 1 and is otherwise ignored; reads of 01h always return the stored code, which is 0 after reset.
- R4: The 512 Hz wave keeps its 64-tick period for every trim code.
- R5: A magnitude of 0 gives no correction for either sign: one second pulse per 2^CNT_W ticks.
- R6: Over each window of WINDOW ticks, a code with sign 1 adds exactly `mag` counts and a code with sign 0 drops exactly `mag` ticks, so the counter advances WINDOW+mag or WINDOW-mag. A write to the trim register restarts the window.
- R7: Corrections are spread evenly: two successive corrections lie at least floor(WINDOW/mag) ticks apart, so the spacing between second pulses varies by only a few ticks.
- R8: `sec_pulse` is a single-cycle pulse, one cycle after the tick on which the corrected counter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oscillator tick enable, one cycle per oscillator period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for reads and writes |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `addr` |
| alarm_hit | input | 1 | Alarm event from the timekeeping logic |
| acs_out | output | 1 | Shared pin: 512 Hz wave in trim mode, alarm otherwise |
| alarm_en | output | 1 | Alarm enable, low while trimming |
| sec_pulse | output | 1 | One-cycle enable per corrected second |

## Verification
The bench builds the block with CNT_W=7 and WINDOW=128, so one "second" and one correction window are both 128 ticks. Under these values 128 windows take 16,384 ticks, and the exact pulse count of 128+mag or 128-mag can be observed for the extreme codes ±31, for zero with either sign, and for small codes. Over the same runs the bench measures the spacing of second pulses against the ideal 16384/(128±mag), and checks that the 512 Hz edges never move.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int TRIM_MAG_W = 5;
  localparam logic [7:0] ADDR_MODE = 8'h00;
  localparam logic [7:0] ADDR_TRIM = 8'h01;
  localparam int MODE_BIT = 0;
  localparam int SIGN_BIT = 5;

  typedef struct packed {
    logic                  sign;
    logic [TRIM_MAG_W-1:0] mag;
  } trim_t;

  // counter increment for one cycle: 0 idle/drop, 1 normal, 2 added count
  function automatic logic [1:0] corr_step(input logic tk, input logic ev, input logic sgn);
    if (!tk) return 2'd0;
    if (!ev) return 2'd1;
    return sgn ? 2'd2 : 2'd0;
  endfunction
endpackage

// File: rtl/rtc_cal_regs.sv
module rtc_cal_regs
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       trim_mode,
  output trim_t      trim,
  output logic       trim_wr
);
  logic mode_wr;
  assign mode_wr = wr_en && (addr == ADDR_MODE);
  assign trim_wr = wr_en && (addr == ADDR_TRIM) && trim_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_mode <= 1'b0;
      trim      <= '0;
    end else begin
      if (mode_wr) trim_mode <= wr_data[MODE_BIT];
      if (trim_wr) trim <= trim_t'({wr_data[SIGN_BIT], wr_data[TRIM_MAG_W-1:0]});
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_MODE) rd_data[MODE_BIT] = trim_mode;
    else if (addr == ADDR_TRIM) rd_data[SIGN_BIT:0] = trim;
  end

  // R3: trim code cannot change while trim mode is off
  p_trim_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !trim_mode |=> $stable(trim));
endmodule

// File: rtl/rtc_corr_sched.sv
module rtc_corr_sched
  import rtc_cal_pkg::*;
#(
  parameter int WINDOW = 230400
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  restart,
  input  logic [TRIM_MAG_W-1:0] mag,
  output logic                  corr_event
);
  localparam int WIN_W = $clog2(WINDOW);
  localparam int ACC_W = $clog2(WINDOW + (1 << TRIM_MAG_W));

  logic [WIN_W-1:0] win_cnt;
  logic [ACC_W-1:0] acc, acc_sum;
  logic             win_last;

  assign win_last   = (win_cnt == WIN_W'(WINDOW - 1));
  assign acc_sum    = acc + ACC_W'(mag);
  assign corr_event = tick && !restart && (acc_sum >= ACC_W'(WINDOW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      acc     <= '0;
    end else if (restart) begin
      win_cnt <= '0;
      acc     <= '0;
    end else if (tick) begin
      win_cnt <= win_last ? '0 : win_cnt + 1'b1;
      acc     <= win_last ? '0 : (corr_event ? acc_sum - ACC_W'(WINDOW) : acc_sum);
    end
  end

  // checker state: events per window and spacing between events
  logic [WIN_W:0] ev_cnt, gap_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_cnt  <= '0;
      gap_cnt <= '0;
    end else if (restart) begin
      ev_cnt  <= '0;
      gap_cnt <= '0;
    end else if (tick) begin
      ev_cnt  <= win_last ? '0 : ev_cnt + (WIN_W+1)'(corr_event);
      gap_cnt <= (win_last || corr_event) ? '0 : gap_cnt + 1'b1;
    end
  end

  // R6: exactly mag corrections in every full window
  p_count_per_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && win_last && !restart) |-> (ev_cnt + (WIN_W+1)'(corr_event)) == (WIN_W+1)'(mag));
  // R5: zero magnitude never corrects
  p_zero_mag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mag == '0) |-> !corr_event);
  // R7: spacing of at least floor(WINDOW/mag) ticks
  p_even_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    corr_event |-> ((32'(gap_cnt) + 32'd2) * 32'(mag)) > 32'(WINDOW));
endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_cal_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int TAP_BIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic corr_event,
  input  logic corr_sign,
  output logic wave_512,
  output logic sec_pulse
);
  localparam int TAP_W = TAP_BIT + 1;

  logic [TAP_W-1:0] tap_cnt;
  logic [CNT_W-1:0] sec_cnt;
  logic [CNT_W:0]   sec_sum;
  logic [1:0]       step;
  logic             wrap;

  assign step    = corr_step(tick, corr_event, corr_sign);
  assign sec_sum = {1'b0, sec_cnt} + (CNT_W+1)'(step);
  assign wrap    = sec_sum[CNT_W];
  assign wave_512 = tap_cnt[TAP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_cnt   <= '0;
      sec_cnt   <= '0;
      sec_pulse <= 1'b0;
    end else begin
      if (tick) tap_cnt <= tap_cnt + 1'b1;
      sec_cnt   <= sec_sum[CNT_W-1:0];
      sec_pulse <= wrap;
    end
  end

  // R4: the tap counter ignores corrections
  p_tap_uncorrected_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && corr_event) |=> tap_cnt == $past(tap_cnt) + 1'b1);
  // R8: a second pulse is never longer than one cycle
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse);
endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler
  import rtc_cal_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int TAP_BIT = 5,
  parameter int WINDOW  = 230400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       alarm_hit,
  output logic       acs_out,
  output logic       alarm_en,
  output logic       sec_pulse
);
  logic  trim_mode, trim_wr, corr_event, wave_512;
  trim_t trim;

  rtc_cal_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .trim_mode(trim_mode), .trim(trim), .trim_wr(trim_wr)
  );

  rtc_corr_sched #(.WINDOW(WINDOW)) u_sched (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(trim_wr),
    .mag(trim.mag), .corr_event(corr_event)
  );

  rtc_div_chain #(.CNT_W(CNT_W), .TAP_BIT(TAP_BIT)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick), .corr_event(corr_event),
    .corr_sign(trim.sign), .wave_512(wave_512), .sec_pulse(sec_pulse)
  );

  assign alarm_en = !trim_mode;
  assign acs_out  = trim_mode ? wave_512 : alarm_hit;

  // R2: alarm gated whenever trim mode is on
  p_alarm_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[MODE_BIT] && addr == ADDR_MODE) |-> !alarm_en);
endmodule

// File: tb/tb_rtc_cal_prescaler.sv
module tb_rtc_cal_prescaler;
  localparam int CNT_W = 7;
  localparam int WIN   = 128;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, alarm_hit = 0;
  logic [7:0] addr = 0, wr_data = 0, rd_data;
  logic acs_out, alarm_en, sec_pulse;

  int errors = 0, checks = 0;
  longint cyc = 0;

  rtc_cal_prescaler #(.CNT_W(CNT_W), .TAP_BIT(5), .WINDOW(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .alarm_hit(alarm_hit),
    .acs_out(acs_out), .alarm_en(alarm_en), .sec_pulse(sec_pulse)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // vector: [15] sign, [14:10] magnitude, [9:0] expected pulses over 128 windows
  localparam logic [15:0] VEC [6] = '{
    {1'b1, 5'd31, 10'd159}, {1'b0, 5'd31, 10'd97}, {1'b0, 5'd0, 10'd128},
    {1'b1, 5'd0, 10'd128},  {1'b1, 5'd1, 10'd129}, {1'b0, 5'd5, 10'd123}};

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor state
  bit     meas = 0, have_sec = 0, have_rise = 0, acs_prev = 0;
  longint last_sec = 0, last_rise = 0;
  int     npulse = 0;
  real    ideal = 128.0;

  always @(negedge clk) begin
    if (meas && sec_pulse) begin
      npulse++;
      if (have_sec) begin
        real d;
        d = real'(cyc - last_sec) - ideal;
        check(d <= 3.0 && d >= -3.0, "R7 second spacing", cyc - last_sec, longint'(ideal));
      end
      have_sec = 1; last_sec = cyc;
    end
    if (meas && acs_out && !acs_prev) begin
      if (have_rise) check(cyc - last_rise == 64, "R4 512Hz period", cyc - last_rise, 64);
      have_rise = 1; last_rise = cyc;
    end
    acs_prev = acs_out;
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rd_data;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    #1;
    // reset state
    check(alarm_en == 1, "R2 reset alarm_en", alarm_en, 1);
    rst_n = 1;
    rd(8'h00, v); check(v == 8'h00, "R1 reset mode reg", v, 0);
    rd(8'h01, v); check(v == 8'h00, "R3 reset trim reg", v, 0);
    check(sec_pulse == 0, "R8 reset sec_pulse", sec_pulse, 0);

    // R3: write ignored with trim mode off
    wr(8'h01, 8'h3F);
    rd(8'h01, v); check(v == 8'h00, "R3 locked write", v, 0);
    // R2: alarm routing with trim mode off
    alarm_hit = 1; #1;
    check(acs_out == 1 && alarm_en == 1, "R2 alarm routed high", acs_out, 1);
    alarm_hit = 0; #1;
    check(acs_out == 0, "R2 alarm routed low", acs_out, 0);

    // R1: enter trim mode
    wr(8'h00, 8'h01);
    rd(8'h00, v); check(v == 8'h01, "R1 mode readback", v, 1);
    alarm_hit = 1; #1;
    check(alarm_en == 0, "R2 alarm gated in trim mode", alarm_en, 0);
    alarm_hit = 0;

    foreach (VEC[i]) begin
      wr(8'h01, {2'b00, VEC[i][15], VEC[i][14:10]});
      rd(8'h01, v);
      check(v == {2'b00, VEC[i][15], VEC[i][14:10]}, "R3 trim readback", v, {VEC[i][15], VEC[i][14:10]});
      ideal = 16384.0 / (VEC[i][15] ? 128.0 + real'(VEC[i][14:10]) : 128.0 - real'(VEC[i][14:10]));
      npulse = 0; have_sec = 0; have_rise = 0; meas = 1;
      @(negedge clk); tick = 1;
      repeat (128 * WIN) @(negedge clk);
      tick = 0;
      repeat (3) @(negedge clk);
      meas = 0;
      check(npulse == int'(VEC[i][9:0]),
            VEC[i][14:10] == 0 ? "R5 zero code pulses" : "R6 pulses per 128 windows",
            npulse, VEC[i][9:0]);
    end

    // R2: leaving trim mode restores the alarm path; R3 locked again
    wr(8'h00, 8'h00);
    alarm_hit = 1; #1;
    check(acs_out == 1 && alarm_en == 1, "R2 exit trim mode", acs_out, 1);
    wr(8'h01, 8'h21);
    rd(8'h01, v); check(v == 8'h05, "R3 write ignored after exit", v, 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule